// File: doc/BRIEF.md
# Fractional product rounding and saturation

This block takes a wide signed fractional product, such as the double-width result of a square two's complement multiply. It narrows that product to a shorter output word. The product carries two sign bits at its top. The output keeps the lower of them, the next-most-significant bit, followed by the next `OUT_W-1` bits. Everything below that field is discarded.

A 2-bit mode input picks how the discarded bits are reduced:
- plain truncation;
- round half up;
- convergent rounding, where a tie goes to an even result;
- up-magnitude rounding, where a tie goes to the larger magnitude.

After rounding, the block checks the sign bits for overflow. An out-of-range result is clamped to the positive or negative full-scale value, and an overflow flag is raised for that sample.

A producer places one product per cycle on `in_prod` with `in_vld` high. The narrowed word, its valid and its overflow flag appear on the registered outputs one clock later. When `in_vld` is low, the output word and the flag keep their last values.

Top module: `frac_round_sat`

## Requirements
- R1: Let D = IN_W-OUT_W-1. When no overflow occurs, `out_data` equals bits IN_W-2 down to D of the rounded product, and the two's complement value of `out_data` equals the rounded product value scaled by 2^-D.
- R2: Mode 2'b00 truncates: bits D-1..0 are dropped with no adjustment.
- R3: Mode 2'b01 rounds half up: the result is incremented by one output LSB when bit D-1 of the product is 1. This means discarded bits at or above one half round up and those below round down.
- R4: Mode 2'b10 (convergent) acts like mode 2'b01, except on an exact tie, where the discarded bits are 1 followed by zeros. On a tie, the result is incremented only when the retained LSB (product bit D) is 1.
- R5: Mode 2'b11 (up-magnitude) acts like mode 2'b01, except on an exact tie. On a tie, the result is incremented when the product sign bit (bit IN_W-1) is 0 and truncated when it is 1.
- R6: If the rounded result does not fit OUT_W signed bits, `out_ovf` is 1. A positive overflow gives `out_data` = 0 followed by all ones. A negative overflow gives 1 followed by all zeros. Otherwise `out_ovf` is 0.
- R7: A rounding increment that carries out of the positive range saturates to positive full scale with `out_ovf` = 1 and never wraps negative (e.g. 16'h3FFF in mode 2'b01 gives 8'h7F).
- R8: The product 0 1 followed by zeros, which is the result of −1 × −1, gives positive full scale with `out_ovf` = 1 in every mode.
- R9: `out_vld` equals `in_vld` of the previous cycle. `out_data` and `out_ovf` reflect the product presented with that `in_vld`.
- R10: While `in_vld` is 0, `out_data` and `out_ovf` hold their values whatever `in_prod` and `in_mode` do.
- R11: A synchronous active-high `rst` clears `out_data`, `out_vld` and `out_ovf` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Product valid strobe |
| in_prod | input | IN_W | Signed fractional product with two sign bits |
| in_mode | input | 2 | Reduction mode: 00 truncate, 01 half up, 10 convergent, 11 up-magnitude |
| out_data | output | OUT_W | Narrowed, rounded and saturated word |
| out_vld | output | 1 | Output valid, one cycle after `in_vld` |
| out_ovf | output | 1 | Overflow of the current sample |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency and the hold of the output while no sample arrives;
- that a saturating sample leaves exactly the full-scale pattern of its direction;
- that truncation without overflow copies the product field;
- that rounding moves the result by at most one LSB;
- the −1 × −1 pattern.

Some behaviour only the bench's scenarios can show:
- tie-breaking that depends on the retained LSB or on the sign;
- a rounding carry that crosses full scale;
- recovery from a mid-stream reset.

The bench checks these against a real-valued model on chosen ties and random products.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [1:0] {
    FRS_TRUNC      = 2'b00,
    FRS_HALF_UP    = 2'b01,
    FRS_CONVERGENT = 2'b10,
    FRS_UP_MAG     = 2'b11
  } frs_mode_e;
endpackage

// File: rtl/frs_round.sv
module frs_round
  import frs_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]   prod,
  input  frs_mode_e         mode,
  output logic [OUT_W+1:0]  kept,
  output logic              tie,
  output logic              bump
);
  localparam int D      = IN_W - OUT_W - 1;
  localparam int KEEP_W = OUT_W + 2;
  localparam logic [D-1:0] TIE_PAT = D'(1) << (D - 1);

  // decide whether one output LSB is added
  function automatic logic bump_fn(frs_mode_e m, logic is_tie, logic half_bit,
                                   logic lsb, logic neg);
    case (m)
      FRS_TRUNC:      bump_fn = 1'b0;
      FRS_HALF_UP:    bump_fn = half_bit;
      FRS_CONVERGENT: bump_fn = is_tie ? lsb : half_bit;
      default:        bump_fn = is_tie ? ~neg : half_bit;
    endcase
  endfunction

  logic [KEEP_W-1:0] upper;

  always_comb begin
    // sign-extended upper field: ext sign, two product sign bits, OUT_W-1 bits
    upper = {prod[IN_W-1], prod[IN_W-1:D]};
    tie   = (prod[D-1:0] == TIE_PAT);
    bump  = bump_fn(mode, tie, prod[D-1], prod[D], prod[IN_W-1]);
    kept  = upper + {{(KEEP_W-1){1'b0}}, bump};
  end
endmodule

// File: rtl/frs_saturate.sv
module frs_saturate #(
  parameter int OUT_W = 8
) (
  input  logic [OUT_W+1:0] kept,
  output logic [OUT_W-1:0] word,
  output logic             ovf,
  output logic             sat_pos,
  output logic             sat_neg
);
  localparam logic [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_FS = {1'b1, {(OUT_W-1){1'b0}}};

  // value fits when extension bit and both sign bits agree
  function automatic logic fits_fn(logic [2:0] top);
    fits_fn = (top == 3'b000) || (top == 3'b111);
  endfunction

  always_comb begin
    ovf     = ~fits_fn(kept[OUT_W+1:OUT_W-1]);
    sat_pos = ovf & ~kept[OUT_W+1];
    sat_neg = ovf &  kept[OUT_W+1];
    if (sat_pos)      word = POS_FS;
    else if (sat_neg) word = NEG_FS;
    else              word = kept[OUT_W-1:0];
  end
endmodule

// File: rtl/frac_round_sat.sv
module frac_round_sat
  import frs_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  in_prod,
  input  logic [1:0]       in_mode,
  output logic [OUT_W-1:0] out_data,
  output logic             out_vld,
  output logic             out_ovf
);
  localparam int KEEP_W = OUT_W + 2;

  frs_mode_e         mode_w;
  logic [KEEP_W-1:0] kept_w;
  logic              tie_w;
  logic              bump_w;
  logic [OUT_W-1:0]  word_w;
  logic              ovf_w;
  logic              sat_pos_w;
  logic              sat_neg_w;

  assign mode_w = frs_mode_e'(in_mode);

  frs_round #(.IN_W(IN_W), .OUT_W(OUT_W)) u_round (
    .prod (in_prod),
    .mode (mode_w),
    .kept (kept_w),
    .tie  (tie_w),
    .bump (bump_w)
  );

  frs_saturate #(.OUT_W(OUT_W)) u_sat (
    .kept    (kept_w),
    .word    (word_w),
    .ovf     (ovf_w),
    .sat_pos (sat_pos_w),
    .sat_neg (sat_neg_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
      out_vld  <= 1'b0;
      out_ovf  <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_data <= word_w;
        out_ovf  <= ovf_w;
      end
    end
  end
endmodule

// File: rtl/frs_checker.sv
module frs_checker #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic [IN_W-1:0]  in_prod,
  input logic [1:0]       in_mode,
  input logic [OUT_W-1:0] out_data,
  input logic             out_vld,
  input logic             out_ovf,
  input logic             tie,
  input logic             bump,
  input logic             sat_pos,
  input logic             sat_neg
);
  localparam int D = IN_W - OUT_W - 1;
  localparam logic [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_FS = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [IN_W-1:0]  MINUS_SQ = {2'b01, {(IN_W-2){1'b0}}};

  p_vld_follow_r9: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  p_vld_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(out_data) && $stable(out_ovf)));
  p_sat_pos_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && sat_pos) |=> (out_ovf && out_data == POS_FS));
  p_sat_neg_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && sat_neg) |=> (out_ovf && out_data == NEG_FS));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !sat_pos && !sat_neg) |=> !out_ovf);
  p_trunc_field_r2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_mode == 2'b00 && !sat_pos && !sat_neg)
      |=> (out_data == $past(in_prod[IN_W-2:D])));
  p_round_step_r3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !sat_pos && !sat_neg)
      |=> ((out_data == $past(in_prod[IN_W-2:D])) ||
           (out_data == $past(in_prod[IN_W-2:D]) + OUT_W'(1))));
  p_tie_conv_r4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && tie && in_mode == 2'b10) |-> (bump == in_prod[D]));
  p_tie_upmag_r5: assert property (@(posedge clk) disable iff (rst)
    (in_vld && tie && in_mode == 2'b11) |-> (bump == !in_prod[IN_W-1]));
  p_minus_sq_r8: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_prod == MINUS_SQ) |=> (out_ovf && out_data == POS_FS));
endmodule

bind frac_round_sat frs_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_vld   (in_vld),
  .in_prod  (in_prod),
  .in_mode  (in_mode),
  .out_data (out_data),
  .out_vld  (out_vld),
  .out_ovf  (out_ovf),
  .tie      (tie_w),
  .bump     (bump_w),
  .sat_pos  (sat_pos_w),
  .sat_neg  (sat_neg_w)
);

// File: tb/tb_frac_round_sat.sv
`timescale 1ns/1ps
module tb_frac_round_sat;
  localparam int IN_W  = 16;
  localparam int OUT_W = 8;
  localparam int D     = IN_W - OUT_W - 1;
  localparam int NV    = 27;

  // {prod[26:11], mode[10:9], out[8:1], ovf[0]}
  localparam logic [26:0] VEC [NV] = '{
    {16'h1234, 2'd0, 8'h24, 1'b0}, {16'h1234, 2'd1, 8'h24, 1'b0},
    {16'h1240, 2'd1, 8'h25, 1'b0}, {16'h1240, 2'd2, 8'h24, 1'b0},
    {16'h12C0, 2'd2, 8'h26, 1'b0}, {16'h1240, 2'd3, 8'h25, 1'b0},
    {16'hEDC0, 2'd3, 8'hDB, 1'b0}, {16'hEDC0, 2'd1, 8'hDC, 1'b0},
    {16'hEDC0, 2'd2, 8'hDC, 1'b0}, {16'hEDC0, 2'd0, 8'hDB, 1'b0},
    {16'h4000, 2'd1, 8'h7F, 1'b1}, {16'h3FFF, 2'd1, 8'h7F, 1'b1},
    {16'h3FFF, 2'd0, 8'h7F, 1'b0}, {16'h8000, 2'd0, 8'h80, 1'b1},
    {16'hC000, 2'd0, 8'h80, 1'b0}, {16'hBFC0, 2'd1, 8'h80, 1'b0},
    {16'hBFC0, 2'd3, 8'h80, 1'b1}, {16'hBFC0, 2'd0, 8'h80, 1'b1},
    {16'hBFC0, 2'd2, 8'h80, 1'b0}, {16'h0000, 2'd3, 8'h00, 1'b0},
    {16'h3FC0, 2'd2, 8'h7F, 1'b1}, {16'h3FC0, 2'd0, 8'h7F, 1'b0},
    {16'h3FC0, 2'd3, 8'h7F, 1'b1}, {16'hFFC0, 2'd3, 8'hFF, 1'b0},
    {16'hFFC0, 2'd2, 8'h00, 1'b0}, {16'hFFC0, 2'd1, 8'h00, 1'b0},
    {16'h00C0, 2'd1, 8'h02, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_vld = 1'b0;
  logic [IN_W-1:0]  in_prod = '0;
  logic [1:0]       in_mode = 2'b00;
  logic [OUT_W-1:0] out_data;
  logic             out_vld;
  logic             out_ovf;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  frac_round_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_prod(in_prod),
    .in_mode(in_mode), .out_data(out_data), .out_vld(out_vld),
    .out_ovf(out_ovf)
  );

  // real-valued model of narrowing, rounding and clamping
  task automatic ref_model(input logic [IN_W-1:0] p, input logic [1:0] m,
                           output logic [OUT_W-1:0] o, output logic ov);
    real    q, t, fr;
    longint ti, r, hi, lo;
    q  = $itor($signed(p)) / (2.0 ** D);
    t  = $floor(q);
    fr = q - t;
    ti = longint'(t);
    case (m)
      2'd0: r = ti;
      2'd1: r = (fr >= 0.5) ? ti + 1 : ti;
      2'd2: r = (fr > 0.5) ? ti + 1 : (fr == 0.5) ? ti + longint'(ti[0]) : ti;
      default: r = (fr > 0.5) ? ti + 1 : (fr == 0.5) ? ((q >= 0.0) ? ti + 1 : ti) : ti;
    endcase
    hi = (longint'(1) <<< (OUT_W - 1)) - 1;
    lo = -(longint'(1) <<< (OUT_W - 1));
    ov = 1'b0;
    if (r > hi) begin r = hi; ov = 1'b1; end
    if (r < lo) begin r = lo; ov = 1'b1; end
    o = r[OUT_W-1:0];
  endtask

  task automatic check(input string tag, input logic [OUT_W-1:0] got_d,
                       input logic [OUT_W-1:0] exp_d, input logic got_o,
                       input logic exp_o);
    n_cmp++;
    if (got_d !== exp_d || got_o !== exp_o) begin
      n_bad++;
      $display("FAIL %s: data=%h ovf=%b expected data=%h ovf=%b",
               tag, got_d, got_o, exp_d, exp_o);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // one sample in, outputs sampled on the following negedge
  task automatic apply(input logic [IN_W-1:0] p, input logic [1:0] m);
    @(negedge clk);
    in_prod = p; in_mode = m; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  function automatic string tag_of(input logic [1:0] m, input logic ov);
    if (ov) return "R6";
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    logic [OUT_W-1:0] eo;
    logic             ev;
    logic [OUT_W-1:0] held;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset", out_data, '0, out_ovf, 1'b0);
    check_bit("R11 reset vld", out_vld, 1'b0);
    rst = 1'b0;

    // table walk covering R2..R6
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][26:11], VEC[i][10:9]);
      check(tag_of(VEC[i][10:9], VEC[i][0]), out_data, VEC[i][8:1],
            out_ovf, VEC[i][0]);
    end

    // R9: valid follows strobe by one cycle
    @(negedge clk);
    in_prod = 16'h0A00; in_mode = 2'd0; in_vld = 1'b1;
    check_bit("R9 vld before", out_vld, 1'b0);
    @(negedge clk);
    in_vld = 1'b0;
    check_bit("R9 vld after", out_vld, 1'b1);
    check("R9 data", out_data, 8'h14, out_ovf, 1'b0);
    @(negedge clk);
    check_bit("R9 vld drop", out_vld, 1'b0);

    // R10: idle inputs leave output untouched
    apply(16'h8000, 2'd1);
    held = out_data;
    in_prod = 16'h1234; in_mode = 2'd2;
    repeat (3) @(negedge clk);
    check("R10 hold", out_data, held, out_ovf, 1'b1);
    check_bit("R10 vld low", out_vld, 1'b0);

    // R8: -1 x -1 pattern in every mode
    for (int m = 0; m < 4; m++) begin
      apply(16'h4000, m[1:0]);
      check("R8 minus-one square", out_data, 8'h7F, out_ovf, 1'b1);
    end

    // R7: rounding carry past positive full scale
    apply(16'h3FFF, 2'd1);
    check("R7 carry half-up", out_data, 8'h7F, out_ovf, 1'b1);
    apply(16'h3FC0, 2'd3);
    check("R7 carry up-mag", out_data, 8'h7F, out_ovf, 1'b1);
    apply(16'h3F80, 2'd1);
    check("R7 just below", out_data, 8'h7F, out_ovf, 1'b0);

    // R1: random products against the real-valued model, half forced ties
    for (int k = 0; k < 400; k++) begin
      logic [IN_W-1:0] p;
      logic [1:0]      m;
      p = IN_W'($urandom);
      m = 2'($urandom);
      if (k[0]) p[D-1:0] = D'(1) << (D - 1);
      apply(p, m);
      ref_model(p, m, eo, ev);
      check("R1 random", out_data, eo, out_ovf, ev);
    end

    // R11: reset in the middle of traffic
    apply(16'h8000, 2'd0);
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b1; in_prod = 16'h4000;
    @(negedge clk);
    check("R11 mid reset", out_data, '0, out_ovf, 1'b0);
    check_bit("R11 mid reset vld", out_vld, 1'b0);
    rst = 1'b0; in_vld = 1'b0;
    apply(16'hEDC0, 2'd3);
    check("R11 after reset", out_data, 8'hDB, out_ovf, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule